// File: doc/BRIEF.md
# External Memory Space Decoder and Wait-State Sequencer

This block sits between a processor core (or a DMA engine) and the off-chip memory port. It takes one access request at a time. Each request carries a 24-bit word address, or, for I/O instructions, a 10-bit immediate that joins a programmable 8-bit I/O page. The block works out which of six off-chip spaces the request targets: four general banks, an I/O space and a boot space. It then drives that space's active-low select for the whole access and reports completion with a one-cycle `done` pulse. A request whose address stays on-chip asserts no select and answers with a one-cycle `miss` pulse instead.

Each space has its own configuration word. The word sets the read and write wait counts, the strobe polarity, the bus width (8 or 16 bits), a write-hold extension and an optional wait for an external ready signal. The configuration is captured when a request is accepted, so a later write to it does not affect an access already in progress. On an 8-bit bus, a 16-bit access is split into two byte cycles at consecutive byte addresses, low byte first. Read data from the two byte cycles is assembled into one 16-bit result.

Top module: `extmem_decoder`

## Requirements
- R1: For a plain (neither I/O nor boot) request, the top 8 address bits select the bank: page 1–63 drives `bank_cs_n[0]` low, 64–127 drives `bank_cs_n[1]`, 128–191 drives `bank_cs_n[2]` and 192–254 drives `bank_cs_n[3]`. At most one select of the six is ever low.
- R2: A plain request to page 0 or page 255 drives no select low and produces a one-cycle `miss` in the cycle after acceptance, with no `done`.
- R3: When `req_io` is set, the 18-bit I/O address is {I/O page, `req_imm`}. If the I/O page is 8 or higher, `io_cs_n` goes low and `ext_addr` carries that address as a word address. If the I/O page is below 8, the addresses 0–8191 stay internal and the request misses. `req_io` takes priority over `req_boot`.
- R4: When `req_boot` is set (and `req_io` is clear), pages 0–62 drive `boot_cs_n` low. Pages 63 and above miss.
- R5: A byte cycle keeps the select low for the wait count plus one cycles. Reads use the read count and writes use the write count. `done` pulses for one cycle in the first cycle after the select returns high.
- R6: Configuration word layout, written through `cfg_we`/`cfg_idx` (index 0–3 are the banks, 4 is I/O, 5 is boot, 6–7 are ignored): bits 3:0 read wait, 7:4 write wait, 8 bus is 16 bits wide, 9 strobes active-high, 10 write-hold extension, 11 wait for `ext_ready`.
- R7: `rd_strobe` (reads) or `wr_strobe` (writes) is at its active level during every counting cycle of the access. The active level is low unless bit 9 of the space's configuration is set.
- R8: With write-hold enabled, each write byte cycle adds one cycle in which the select stays low and `wr_strobe` is inactive.
- R9: On an 8-bit bus, a 16-bit request (`req_wide`) runs two byte cycles, each with the full wait count. The first uses byte address {word, 0} and drives the low data byte on `ext_dout[7:0]`. The second uses {word, 1} and drives the high byte. `ext_dout[15:8]` is zero. On a 16-bit bus, `ext_addr` bit 0 is 0 and the full data word is driven.
- R10: With bit 11 set, the last counting cycle repeats while `ext_ready` is low. Both the select and the strobe are lengthened by the stall.
- R11: `rsp_rdata` is valid with `done`. On a 16-bit bus it holds the full `ext_din`. On an 8-bit bus it holds {second byte, first byte} for a wide read and {0, byte} for a narrow read.
- R12: While `busy` is high, new requests are ignored. A configuration write during an access leaves that access unchanged but applies to the next one.
- R13: After reset, all selects are high, `busy`, `done` and `miss` are low, and every space has read and write wait 3, a 16-bit bus, active-low strobes, no hold and no ready wait. The I/O page resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 16-bit access (split on an 8-bit bus) |
| req_io | input | 1 | I/O-space request using page and immediate |
| req_boot | input | 1 | Boot-space request |
| req_addr | input | 24 | Word address for bank and boot requests |
| req_imm | input | 10 | I/O immediate |
| req_wdata | input | 16 | Write data |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 3 | Space index for configuration write |
| cfg_wdata | input | 12 | Configuration word |
| iopage_we | input | 1 | I/O page write enable |
| iopage_wdata | input | 8 | New I/O page |
| ext_ready | input | 1 | External ready, used when bit 11 is set |
| ext_din | input | 16 | Data from the external bus |
| bank_cs_n | output | 4 | Active-low bank selects |
| io_cs_n | output | 1 | Active-low I/O space select |
| boot_cs_n | output | 1 | Active-low boot space select |
| ext_addr | output | 25 | External byte address |
| ext_dout | output | 16 | Data to the external bus |
| rd_strobe | output | 1 | Read strobe, polarity per space |
| wr_strobe | output | 1 | Write strobe, polarity per space |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| miss | output | 1 | One-cycle pulse for an internal address |
| rsp_rdata | output | 16 | Assembled read data |

## Verification
On every cycle, the assertions check the following:
- At most one select is low.
- A miss never comes with a select or a `done`.
- `done` follows directly after a select cycle, and the select is never active in the `done` cycle.
- Strobes appear only under a select.
- A hold cycle always follows a write-strobe cycle.
- The chosen select does not change during an access.

The page-to-space mapping, the exact lengths of the select and strobe for each wait count, the byte order and addresses on a narrow bus, the ready stall, the assembled read data and the effect of a configuration change during an access depend on the chosen addresses and configurations. Only the bench's scenarios can show these.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  localparam int ADDR_W     = 24;
  localparam int PAGE_W     = 8;
  localparam int IMM_W      = 10;
  localparam int IO_AW      = PAGE_W + IMM_W;
  localparam int DATA_W     = 16;
  localparam int BYTE_W     = DATA_W / 2;
  localparam int WAIT_W     = 4;
  localparam int NUM_SPACES = 6;
  localparam int SPACE_W    = 3;

  typedef enum logic [SPACE_W-1:0] {
    SP_BANK0 = 3'd0, SP_BANK1 = 3'd1, SP_BANK2 = 3'd2, SP_BANK3 = 3'd3,
    SP_IO    = 3'd4, SP_BOOT  = 3'd5
  } space_e;

  // Field order fixes the bit positions software writes (R6).
  typedef struct packed {
    logic              ready_mode;
    logic              wr_hold;
    logic              strobe_hi;
    logic              bus16;
    logic [WAIT_W-1:0] wr_wait;
    logic [WAIT_W-1:0] rd_wait;
  } space_cfg_t;

  localparam int CFG_W = $bits(space_cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_HOLD} acc_state_e;

  // Pages 0 and all-ones stay on chip.
  function automatic logic page_is_ext(input logic [PAGE_W-1:0] pg);
    return (pg != '0) && (pg != '1);
  endfunction

  // Bank index is the top two page bits, which gives four equal ranges.
  function automatic logic [1:0] bank_of_page(input logic [PAGE_W-1:0] pg);
    return pg[PAGE_W-1:PAGE_W-2];
  endfunction

  function automatic logic [IO_AW-1:0] io_word(input logic [PAGE_W-1:0] pg,
                                               input logic [IMM_W-1:0] imm);
    return {pg, imm};
  endfunction

  function automatic logic [ADDR_W:0] byte_addr(input logic [ADDR_W-1:0] word,
                                                input logic half);
    return {word, half};
  endfunction
endpackage

// File: rtl/extmem_cfg_regs.sv
module extmem_cfg_regs
  import extmem_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 12'h133
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SPACE_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              iopage_we,
  input  logic [PAGE_W-1:0] iopage_wdata,
  output space_cfg_t        cfg_q [NUM_SPACES],
  output logic [PAGE_W-1:0] io_page
);
  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_space
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= space_cfg_t'(CFG_RESET);
      else if (cfg_we && (cfg_idx == SPACE_W'(i))) cfg_q[i] <= space_cfg_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_page <= '0;
    else if (iopage_we) io_page <= iopage_wdata;
  end
endmodule

// File: rtl/extmem_addr_decode.sv
module extmem_addr_decode
  import extmem_pkg::*;
#(
  parameter int BOOT_PAGES   = 63,
  parameter int IO_RSV_PAGES = 8
) (
  input  logic              req_io,
  input  logic              req_boot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [PAGE_W-1:0] io_page,
  output logic              is_ext,
  output space_e            space,
  output logic [ADDR_W-1:0] word_addr
);
  logic [PAGE_W-1:0] page;
  assign page = req_addr[ADDR_W-1 -: PAGE_W];

  always_comb begin
    if (req_io) begin
      space     = SP_IO;
      word_addr = {{(ADDR_W-IO_AW){1'b0}}, io_word(io_page, req_imm)};
      is_ext    = 32'(io_page) >= IO_RSV_PAGES;
    end else if (req_boot) begin
      space     = SP_BOOT;
      word_addr = req_addr;
      is_ext    = 32'(page) < BOOT_PAGES;
    end else begin
      space     = space_e'({1'b0, bank_of_page(page)});
      word_addr = req_addr;
      is_ext    = page_is_ext(page);
    end
  end
endmodule

// File: rtl/extmem_access_fsm.sv
module extmem_access_fsm
  import extmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       write,
  input  logic       wide,
  input  space_cfg_t cfg,
  input  logic       ext_ready,
  output space_cfg_t cfg_act,
  output logic       active,
  output logic       rd_on,
  output logic       wr_on,
  output logic       hold_phase,
  output logic       phase,
  output logic       capture,
  output logic       done
);
  acc_state_e        st;
  logic [WAIT_W-1:0] cnt;
  logic              two_bytes, wr_q, done_q;

  logic              count_end, need_hold, more;
  logic [WAIT_W-1:0] reload;

  assign count_end = (st == ST_ACT) && (cnt == '0) && (!cfg_act.ready_mode || ext_ready);
  assign need_hold = wr_q && cfg_act.wr_hold;
  assign more      = two_bytes && !phase;
  assign reload    = wr_q ? cfg_act.wr_wait : cfg_act.rd_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; phase <= 1'b0; two_bytes <= 1'b0;
      wr_q <= 1'b0; cfg_act <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st        <= ST_ACT;
          cfg_act   <= cfg;
          wr_q      <= write;
          two_bytes <= wide && !cfg.bus16;
          phase     <= 1'b0;
          cnt       <= write ? cfg.wr_wait : cfg.rd_wait;
        end
        ST_ACT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (count_end) begin
            if (need_hold) st <= ST_HOLD;
            else if (more) begin phase <= 1'b1; cnt <= reload; end
            else begin st <= ST_IDLE; done_q <= 1'b1; end
          end
        end
        ST_HOLD: begin
          if (more) begin st <= ST_ACT; phase <= 1'b1; cnt <= reload; end
          else begin st <= ST_IDLE; done_q <= 1'b1; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign active     = (st != ST_IDLE);
  assign rd_on      = (st == ST_ACT) && !wr_q;
  assign wr_on      = (st == ST_ACT) && wr_q;
  assign hold_phase = (st == ST_HOLD);
  assign capture    = count_end && !wr_q;
  assign done       = done_q;
endmodule

// File: rtl/extmem_decoder.sv
module extmem_decoder
  import extmem_pkg::*;
#(
  parameter int                BOOT_PAGES   = 63,
  parameter int                IO_RSV_PAGES = 8,
  parameter logic [CFG_W-1:0]  CFG_RESET    = 12'h133
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic                req_io,
  input  logic                req_boot,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [IMM_W-1:0]    req_imm,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                cfg_we,
  input  logic [SPACE_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                iopage_we,
  input  logic [PAGE_W-1:0]   iopage_wdata,
  input  logic                ext_ready,
  input  logic [DATA_W-1:0]   ext_din,
  output logic [3:0]          bank_cs_n,
  output logic                io_cs_n,
  output logic                boot_cs_n,
  output logic [ADDR_W:0]     ext_addr,
  output logic [DATA_W-1:0]   ext_dout,
  output logic                rd_strobe,
  output logic                wr_strobe,
  output logic                busy,
  output logic                done,
  output logic                miss,
  output logic [DATA_W-1:0]   rsp_rdata
);
  space_cfg_t        cfg_all [NUM_SPACES];
  space_cfg_t        cfg_pick, cfg_act;
  logic [PAGE_W-1:0] io_page;
  logic              dec_ext;
  space_e            dec_space, space_l;
  logic [ADDR_W-1:0] dec_word, addr_l;
  logic [DATA_W-1:0] wdata_l, rdata_q;
  logic              accept, start, miss_q;
  logic              active, rd_on, wr_on, hold_phase, phase, capture;
  logic [NUM_SPACES-1:0] sel_n_all;

  extmem_cfg_regs #(.CFG_RESET(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .iopage_we(iopage_we), .iopage_wdata(iopage_wdata),
    .cfg_q(cfg_all), .io_page(io_page)
  );

  extmem_addr_decode #(.BOOT_PAGES(BOOT_PAGES), .IO_RSV_PAGES(IO_RSV_PAGES)) u_dec (
    .req_io(req_io), .req_boot(req_boot), .req_addr(req_addr), .req_imm(req_imm),
    .io_page(io_page), .is_ext(dec_ext), .space(dec_space), .word_addr(dec_word)
  );

  always_comb begin
    cfg_pick = cfg_all[0];
    for (int i = 1; i < NUM_SPACES; i++)
      if (dec_space == SPACE_W'(i)) cfg_pick = cfg_all[i];
  end

  assign accept = req_valid && !active;
  assign start  = accept && dec_ext;

  extmem_access_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .write(req_write), .wide(req_wide),
    .cfg(cfg_pick), .ext_ready(ext_ready), .cfg_act(cfg_act), .active(active),
    .rd_on(rd_on), .wr_on(wr_on), .hold_phase(hold_phase), .phase(phase),
    .capture(capture), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_l <= SP_BANK0; addr_l <= '0; wdata_l <= '0; miss_q <= 1'b0;
    end else begin
      miss_q <= accept && !dec_ext;
      if (start) begin
        space_l <= dec_space; addr_l <= dec_word; wdata_l <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (start) rdata_q <= '0;
    else if (capture) begin
      if (cfg_act.bus16)  rdata_q <= ext_din;
      else if (phase)     rdata_q[DATA_W-1:BYTE_W] <= ext_din[BYTE_W-1:0];
      else                rdata_q[BYTE_W-1:0]      <= ext_din[BYTE_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_sel
    assign sel_n_all[i] = !(active && (space_l == SPACE_W'(i)));
  end

  assign bank_cs_n = sel_n_all[3:0];
  assign io_cs_n   = sel_n_all[SP_IO];
  assign boot_cs_n = sel_n_all[SP_BOOT];
  assign ext_addr  = active ? byte_addr(addr_l, phase) : '0;
  assign ext_dout  = cfg_act.bus16 ? wdata_l
                   : {{BYTE_W{1'b0}}, phase ? wdata_l[DATA_W-1:BYTE_W] : wdata_l[BYTE_W-1:0]};
  assign rd_strobe = cfg_act.strobe_hi ? rd_on : !rd_on;
  assign wr_strobe = cfg_act.strobe_hi ? wr_on : !wr_on;
  assign busy      = active;
  assign miss      = miss_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/extmem_decoder_checks.sv
module extmem_decoder_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] sel_n_all,
  input logic       done,
  input logic       miss,
  input logic       hold_phase,
  input logic       rd_on,
  input logic       wr_on
);
  logic any_sel;
  assign any_sel = (sel_n_all != 6'h3f);

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n_all));

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (sel_n_all == 6'h3f) && !done);

  assert_done_after_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(any_sel) && !any_sel);

  assert_strobe_under_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on || wr_on) |-> any_sel);

  assert_hold_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_phase |-> $past(wr_on) && any_sel);

  assert_select_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel && $past(any_sel)) |-> $stable(sel_n_all));
endmodule

bind extmem_decoder extmem_decoder_checks chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n_all(sel_n_all), .done(done), .miss(miss),
  .hold_phase(hold_phase), .rd_on(rd_on), .wr_on(wr_on)
);

// File: tb/extmem_decoder_tb_top.sv
module extmem_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_wide = 0, req_io = 0, req_boot = 0;
  logic [23:0] req_addr = '0;
  logic [9:0]  req_imm = '0;
  logic [15:0] req_wdata = '0;
  logic cfg_we = 0; logic [2:0] cfg_idx = '0; logic [11:0] cfg_wdata = '0;
  logic iopage_we = 0; logic [7:0] iopage_wdata = '0;
  logic ext_ready = 1'b1;
  logic [15:0] ext_din, ext_dout, rsp_rdata;
  logic [3:0]  bank_cs_n;
  logic io_cs_n, boot_cs_n, rd_strobe, wr_strobe, busy, done, miss;
  logic [24:0] ext_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  extmem_decoder dut_i (.*);

  assign ext_din = {ext_addr[7:0] ^ 8'hA5, ext_addr[7:0]};

  typedef struct {
    bit miss; int idx; int sel_len; int strb_len;
    logic [24:0] a0, a1; logic [15:0] rdata, d0, d1; bit wr; bit pol_hi;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int total = 0, fails = 0, cyc = 0;
  logic [11:0] mcfg [6];
  logic [7:0]  miopg = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Monitor: measures each access at the select lines and compares on done/miss.
  logic [5:0] mon_sel;
  int m_len = 0, m_strb = 0, m_idx = -1;
  logic [24:0] m_a0, m_a1; logic [15:0] m_d0, m_d1;
  bit prev_sel = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      mon_sel = ~{boot_cs_n, io_cs_n, bank_cs_n};
      if (mon_sel != 0) begin
        if (m_len == 0) begin
          m_a0 = ext_addr; m_d0 = ext_dout;
          for (int i = 0; i < 6; i++) if (mon_sel[i]) m_idx = i;
        end
        m_a1 = ext_addr; m_d1 = ext_dout; m_len++;
        if (exp_q.size() > 0)
          if ((exp_q[0].wr ? wr_strobe : rd_strobe) == exp_q[0].pol_hi) m_strb++;
      end
      if (done || miss) begin
        if (exp_q.size() == 0) check(0, "R12", "unexpected response", 1, 0);
        else begin
          exp_t e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(miss == e.miss, t, "miss flag", miss, e.miss);
          if (e.miss) check(m_len == 0, "R2", "select during miss", m_len, 0);
          else begin
            check(m_idx == e.idx, t, "select index", m_idx, e.idx);
            check(m_len == e.sel_len, t, "select length", m_len, e.sel_len);
            check(m_strb == e.strb_len, t, "strobe length", m_strb, e.strb_len);
            check(prev_sel, "R5", "done not right after select", prev_sel, 1);
            check(m_a0 == e.a0, t, "first byte address", m_a0, e.a0);
            check(m_a1 == e.a1, t, "last byte address", m_a1, e.a1);
            if (e.wr) begin
              check(m_d0 == e.d0, t, "first data lane", m_d0, e.d0);
              check(m_d1 == e.d1, t, "last data lane", m_d1, e.d1);
            end else check(rsp_rdata == e.rdata, t, "read data R11", rsp_rdata, e.rdata);
          end
        end
        m_len = 0; m_strb = 0; m_idx = -1;
      end
      prev_sel = (mon_sel != 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic set_cfg(input int idx, input logic [11:0] v);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    if (idx < 6) mcfg[idx] = v;
  endtask

  task automatic set_iopage(input logic [7:0] v);
    @(negedge clk); iopage_we = 1; iopage_wdata = v;
    @(negedge clk); iopage_we = 0; miopg = v;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Driver: computes the expected item from the requirements and drives the request.
  task automatic issue(input string tag, input bit wr, input bit io, input bit boot,
                       input bit wide, input logic [23:0] addr, input logic [9:0] imm,
                       input logic [15:0] wd, input int stall, input bit wait_rsp);
    exp_t e; logic [7:0] pg; logic [17:0] ioa; logic [23:0] word; bit ext;
    int w, bytes, h; logic [11:0] c;
    pg = addr[23:16]; word = addr;
    if (io) begin
      ioa = {miopg, imm}; ext = (ioa >= 18'd8192); e.idx = 4; word = {6'b0, ioa};
    end else if (boot) begin
      ext = (pg < 8'd63); e.idx = 5;
    end else begin
      ext = (pg >= 8'd1) && (pg <= 8'd254);
      e.idx = (pg <= 8'd63) ? 0 : (pg <= 8'd127) ? 1 : (pg <= 8'd191) ? 2 : 3;
    end
    c = mcfg[e.idx];
    w = wr ? int'(c[7:4]) : int'(c[3:0]);
    bytes = (wide && !c[8]) ? 2 : 1;
    h = (wr && c[10]) ? 1 : 0;
    e.miss = !ext; e.wr = wr; e.pol_hi = c[9];
    e.sel_len = bytes * (w + 1 + h) + stall;
    e.strb_len = bytes * (w + 1) + stall;
    e.a0 = {word, 1'b0};
    e.a1 = (bytes == 2) ? {word, 1'b1} : e.a0;
    e.rdata = c[8] ? {e.a0[7:0] ^ 8'hA5, e.a0[7:0]}
            : (bytes == 2) ? {e.a1[7:0], e.a0[7:0]} : {8'h00, e.a0[7:0]};
    e.d0 = c[8] ? wd : {8'h00, wd[7:0]};
    e.d1 = c[8] ? wd : (bytes == 2) ? {8'h00, wd[15:8]} : e.d0;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_io = io; req_boot = boot; req_wide = wide;
    req_addr = addr; req_imm = imm; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (wait_rsp) wait_empty();
  endtask

  initial begin
    for (int i = 0; i < 6; i++) mcfg[i] = 12'h133;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13: reset state at the ports
    check({bank_cs_n, io_cs_n, boot_cs_n} == 6'h3f, "R13", "selects after reset",
          {bank_cs_n, io_cs_n, boot_cs_n}, 6'h3f);
    check(!busy && !done && !miss, "R13", "status after reset", {busy, done, miss}, 0);
    // R13/R5/R11: default config read, bank 0
    issue("R13", 0, 0, 0, 0, 24'h01_0010, 0, 0, 0, 1);
    // R1: page ranges
    issue("R1", 0, 0, 0, 0, 24'h3F_0002, 0, 0, 0, 1);
    issue("R1", 0, 0, 0, 0, 24'h40_0004, 0, 0, 0, 1);
    issue("R1", 0, 0, 0, 0, 24'h80_0006, 0, 0, 0, 1);
    issue("R1", 0, 0, 0, 0, 24'hC0_0008, 0, 0, 0, 1);
    issue("R1", 0, 0, 0, 0, 24'hFE_000A, 0, 0, 0, 1);
    // R2: internal pages
    issue("R2", 0, 0, 0, 0, 24'h00_1234, 0, 0, 0, 1);
    issue("R2", 1, 0, 0, 0, 24'hFF_1234, 0, 16'h1111, 0, 1);
    // R3: I/O space
    set_iopage(8'd8);
    issue("R3", 0, 1, 0, 0, 24'hFF_FFFF, 10'd5, 0, 0, 1);
    issue("R3", 0, 1, 1, 0, 24'h00_0000, 10'h3FF, 0, 0, 1);
    set_iopage(8'd7);
    issue("R3", 0, 1, 0, 0, 24'h01_0000, 10'h3FF, 0, 0, 1);
    // R4: boot space
    issue("R4", 0, 0, 1, 0, 24'h3E_0100, 0, 0, 0, 1);
    issue("R4", 0, 0, 1, 0, 24'h3F_0100, 0, 0, 0, 1);
    // R6/R5: separate read and write counts
    set_cfg(1, 12'h152);
    issue("R5", 0, 0, 0, 0, 24'h41_0000, 0, 0, 0, 1);
    issue("R6", 1, 0, 0, 0, 24'h42_0000, 0, 16'hBEEF, 0, 1);
    set_cfg(7, 12'h000);
    issue("R6", 0, 0, 0, 0, 24'h43_0000, 0, 0, 0, 1);
    // R7: active-high strobes
    set_cfg(2, 12'h322);
    issue("R7", 1, 0, 0, 0, 24'h81_0000, 0, 16'hCAFE, 0, 1);
    issue("R7", 0, 0, 0, 0, 24'h82_0000, 0, 0, 0, 1);
    // R8: write hold
    set_cfg(3, 12'h513);
    issue("R8", 1, 0, 0, 0, 24'hC1_0000, 0, 16'h5A5A, 0, 1);
    issue("R8", 0, 0, 0, 0, 24'hC2_0000, 0, 0, 0, 1);
    // R9/R11: 8-bit bus, split accesses
    set_cfg(0, 12'h412);
    issue("R9", 0, 0, 0, 1, 24'h05_0123, 0, 0, 0, 1);
    issue("R9", 1, 0, 0, 1, 24'h06_0456, 0, 16'hA1B2, 0, 1);
    issue("R11", 0, 0, 0, 0, 24'h07_0789, 0, 0, 0, 1);
    // R10: stall on ready
    set_cfg(2, 12'h911);
    ext_ready = 0;
    issue("R10", 0, 0, 0, 0, 24'h90_0000, 0, 0, 4, 0);
    repeat (5) @(negedge clk);
    ext_ready = 1;
    wait_empty();
    // R12: request and config write while busy
    set_cfg(1, 12'h155);
    issue("R12", 0, 0, 0, 0, 24'h44_0000, 0, 0, 0, 0);
    @(negedge clk); req_valid = 1; req_addr = 24'h00_0000; req_write = 0;
    req_io = 0; req_boot = 0;
    @(negedge clk); req_valid = 0;
    cfg_we = 1; cfg_idx = 3'd1; cfg_wdata = 12'h150;
    @(negedge clk); cfg_we = 0; mcfg[1] = 12'h150;
    wait_empty();
    issue("R12", 0, 0, 0, 0, 24'h45_0000, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12", "responses outstanding", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule